// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Lockout

This block receives asynchronous serial frames on an idle-high line. A falling edge on the line begins a frame. The receiver then confirms the start bit halfway through its bit period. It shifts the data bits in least-significant first. After that it takes the optional parity bit and the stop bits. Every check runs once the frame has ended: the parity check, the stop-bit check and the overrun check. A frame that passes all three lands in the receive data register and raises the data-full flag.

A frame that fails any check sets the matching error flag and leaves the data-full flag alone. From then on the receiver ignores the line until the host clears the error flags. A 16x oversampling tick from outside the block sets the bit timing. The frame format comes from configuration inputs, which are taken at each start bit. The host clears the data-full flag with one strobe and the error flags with another. Two interrupt request lines follow the flags, both gated by one enable input.

Top module: `uart_rx_lockout`

## Requirements
- R1: After reset, rx_data is 0, every flag is 0 and both interrupt lines are 0.
- R2: In 8-bit mode (cfg_short_word=0), the first data bit after the start bit lands in rx_data[0] and the eighth in rx_data[7]. A frame that passes every check sets rx_full.
- R3: In 7-bit mode (cfg_short_word=1), seven data bits are taken into rx_data[6:0] and rx_data[7] reads 0.
- R4: With cfg_par_en=1, the count of ones across the data bits and the parity bit must be even when cfg_par_odd=0 and odd when cfg_par_odd=1. A mismatch sets err_parity and leaves rx_full at 0.
- R5: The first stop bit must be 1, or err_frame is set and rx_full is not set. With cfg_two_stop=1, the value of the second stop bit has no effect.
- R6: A frame that completes while rx_full=1 sets err_overrun. rx_data keeps its old value and rx_full stays 1.
- R7: While any error flag is 1, incoming frames are not received. After err_clr, reception resumes.
- R8: A low pulse shorter than half a bit period does not start a frame.
- R9: irq_rx equals irq_en AND rx_full. irq_err equals irq_en AND the OR of the three error flags.
- R10: rd_ack clears rx_full and err_clr clears the three error flags. A flag set in the same cycle as its clear strobe ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | 16x oversampling enable |
| rxd | input | 1 | Serial line, idle high |
| cfg_short_word | input | 1 | 1 = 7 data bits, 0 = 8 |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| irq_en | input | 1 | Receive interrupt enable |
| rd_ack | input | 1 | Clears rx_full |
| err_clr | input | 1 | Clears the error flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive data full flag |
| err_overrun | output | 1 | Overrun flag |
| err_parity | output | 1 | Parity error flag |
| err_frame | output | 1 | Framing error flag |
| irq_rx | output | 1 | Data-full interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |

## Verification
A frame's result is decided at the middle of its first stop bit. That moment falls two synchronizer cycles plus eight oversampling ticks after the stop bit begins on the line. The flags and rx_data change on the next clock edge after that. The bench therefore drives each whole frame, keeps the line high for forty more cycles and only then samples on a falling clock edge. A strobe takes effect at the next rising edge, so the bench samples its effect at the falling edge that follows.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic short_word;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } rx_cfg_t;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    input  logic          lock,
    input  rx_cfg_t       cfg_i,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          pbit,
    output logic          stop_ok,
    output rx_cfg_t       cfg_o
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW);
    localparam logic [CW-1:0] MID   = CW'(OVS/2 - 1);
    localparam logic [CW-1:0] LASTT = CW'(OVS - 1);
    localparam logic [BW-1:0] LAST_FULL  = BW'(DW - 1);
    localparam logic [BW-1:0] LAST_SHORT = BW'(DW - 2);

    typedef struct packed {
        rx_state_e     state;
        logic [CW-1:0] cnt;
        logic [BW-1:0] nbit;
        logic [DW-1:0] sh;
        rx_cfg_t       cfg;
        logic          pbit;
        logic          stop_ok;
        logic          done;
        logic          rx_prev;
    } fr_t;

    fr_t d, q;
    logic [BW-1:0] last_bit;
    logic          at_end;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        last_bit = q.cfg.short_word ? LAST_SHORT : LAST_FULL;
        at_end   = (q.cnt == LASTT);
        if (tick) begin
            d.rx_prev = rx;
            unique case (q.state)
                ST_IDLE: begin
                    if (q.rx_prev && !rx && !lock) begin
                        d.state = ST_START;
                        d.cnt   = '0;
                        d.nbit  = '0;
                        d.sh    = '0;
                        d.cfg   = cfg_i;
                    end
                end
                ST_START: begin
                    if (q.cnt == MID) begin
                        d.cnt   = '0;
                        d.state = rx ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (at_end) begin
                        d.cnt = '0;
                        d.sh  = {rx, q.sh[DW-1:1]};
                        if (q.nbit == last_bit)
                            d.state = q.cfg.par_en ? ST_PAR : ST_STOP1;
                        else
                            d.nbit = q.nbit + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_end) begin
                        d.cnt   = '0;
                        d.pbit  = rx;
                        d.state = ST_STOP1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP1: begin
                    if (at_end) begin
                        d.cnt     = '0;
                        d.stop_ok = rx;
                        d.done    = 1'b1;
                        d.state   = q.cfg.two_stop ? ST_STOP2 : ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_STOP2: begin
                    if (at_end) begin
                        d.cnt   = '0;
                        d.state = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.state   <= ST_IDLE;
            q.rx_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done    = q.done;
    assign data    = q.cfg.short_word ? {1'b0, q.sh[DW-1:1]} : q.sh;
    assign pbit    = q.pbit;
    assign stop_ok = q.stop_ok;
    assign cfg_o   = q.cfg;

    // R7
    lockout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && lock) |=> (q.state == ST_IDLE));

    // R8
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_START && tick && q.cnt == MID && rx) |=> (q.state == ST_IDLE && !q.done));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] data,
    input  logic          pbit,
    input  logic          stop_ok,
    input  rx_cfg_t       cfg,
    input  logic          rd_ack,
    input  logic          err_clr,
    input  logic          irq_en,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          ovr,
    output logic          perr,
    output logic          ferr,
    output logic          irq_rx,
    output logic          irq_err,
    output logic          lock
);
    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          full;
        logic          ovr;
        logic          perr;
        logic          ferr;
    } st_t;

    st_t  d, q;
    logic par_bad, stop_bad, ovr_bad;

    always_comb begin
        d        = q;
        par_bad  = cfg.par_en && ((^data ^ pbit) != cfg.par_odd);
        stop_bad = !stop_ok;
        ovr_bad  = q.full;
        if (rd_ack)  d.full = 1'b0;
        if (err_clr) begin
            d.ovr  = 1'b0;
            d.perr = 1'b0;
            d.ferr = 1'b0;
        end
        if (done) begin
            if (par_bad || stop_bad || ovr_bad) begin
                if (par_bad)  d.perr = 1'b1;
                if (stop_bad) d.ferr = 1'b1;
                if (ovr_bad)  d.ovr  = 1'b1;
            end else begin
                d.rdata = data;
                d.full  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata   = q.rdata;
    assign full    = q.full;
    assign ovr     = q.ovr;
    assign perr    = q.perr;
    assign ferr    = q.ferr;
    assign lock    = q.ovr | q.perr | q.ferr;
    assign irq_rx  = irq_en & q.full;
    assign irq_err = irq_en & lock;

    // R6
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.full && !rd_ack) |=> (q.ovr && q.full && $stable(q.rdata)));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !stop_ok) |=> q.ferr);

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stop_ok && !cfg.par_en && !q.full) |=> (q.full && q.rdata == $past(data)));

    // R5
    no_full_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !stop_ok && !q.full) |=> !q.full);
endmodule

// File: rtl/uart_rx_lockout.sv
module uart_rx_lockout
    import uart_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          os_tick,
    input  logic          rxd,
    input  logic          cfg_short_word,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          cfg_two_stop,
    input  logic          irq_en,
    input  logic          rd_ack,
    input  logic          err_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          err_overrun,
    output logic          err_parity,
    output logic          err_frame,
    output logic          irq_rx,
    output logic          irq_err
);
    logic          rx_s, lock, done, pbit, stop_ok;
    logic [DW-1:0] data;
    rx_cfg_t       cfg_in, cfg_fr;

    assign cfg_in = '{short_word: cfg_short_word, par_en: cfg_par_en,
                      par_odd: cfg_par_odd, two_stop: cfg_two_stop};

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    uart_rx_frame #(.OVS(OVS), .DW(DW)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rx(rx_s), .lock(lock),
        .cfg_i(cfg_in), .done(done), .data(data), .pbit(pbit),
        .stop_ok(stop_ok), .cfg_o(cfg_fr)
    );

    uart_rx_status #(.DW(DW)) u_status (
        .clk(clk), .rst_n(rst_n), .done(done), .data(data), .pbit(pbit),
        .stop_ok(stop_ok), .cfg(cfg_fr), .rd_ack(rd_ack), .err_clr(err_clr),
        .irq_en(irq_en), .rdata(rx_data), .full(rx_full), .ovr(err_overrun),
        .perr(err_parity), .ferr(err_frame), .irq_rx(irq_rx), .irq_err(irq_err),
        .lock(lock)
    );
endmodule

// File: tb/sim_uart_rx_lockout.sv
module sim_uart_rx_lockout;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic c_short = 1'b0, c_pen = 1'b0, c_odd = 1'b0, c_two = 1'b0;
    logic irq_en = 1'b1, rd_ack = 1'b0, err_clr = 1'b0;
    logic [7:0] rx_data;
    logic rx_full, err_overrun, err_parity, err_frame, irq_rx, irq_err;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    uart_rx_lockout u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rxd(rxd),
        .cfg_short_word(c_short), .cfg_par_en(c_pen), .cfg_par_odd(c_odd),
        .cfg_two_stop(c_two), .irq_en(irq_en), .rd_ack(rd_ack), .err_clr(err_clr),
        .rx_data(rx_data), .rx_full(rx_full), .err_overrun(err_overrun),
        .err_parity(err_parity), .err_frame(err_frame), .irq_rx(irq_rx),
        .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rxd = b;
        repeat (16) @(negedge clk);
    endtask

    // bad_par inverts the parity bit; s1/s2 are the stop bit values
    task automatic send(input logic [7:0] v, input logic bad_par, input logic s1, input logic s2);
        int nb;
        logic p;
        nb = c_short ? 7 : 8;
        p = c_odd;
        drive_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            drive_bit(v[i]);
            p = p ^ v[i];
        end
        if (c_pen) drive_bit(p ^ bad_par);
        drive_bit(s1);
        if (c_two) drive_bit(s2);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic pulse_ack();
        rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 data", rx_data, 0);
        check("R1 flags", {rx_full, err_overrun, err_parity, err_frame}, 0);
        check("R1 irq", {irq_rx, irq_err}, 0);
        repeat (20) @(negedge clk);

        // R2 R3 R4 R5 R9 R10: sweep all 16 format combinations
        for (int c = 0; c < 16; c++) begin
            {c_short, c_pen, c_odd, c_two} = 4'(c);
            for (int k = 0; k < 3; k++) begin
                logic [7:0] v, e;
                v = (k == 0) ? 8'hA5 : (k == 1) ? 8'h3C : 8'(c * 17 + 1);
                e = c_short ? (v & 8'h7F) : v;
                send(v, 1'b0, 1'b1, 1'b1);
                check(c_short ? "R3 data" : "R2 data", rx_data, e);
                check("R2 full", rx_full, 1);
                check("R4 R5 no error", {err_overrun, err_parity, err_frame}, 0);
                check("R9 irq_rx", {irq_rx, irq_err}, 2'b10);
                pulse_ack();
                check("R10 ack clears", rx_full, 0);
            end
        end

        // R4 parity error, then R7 lockout
        {c_short, c_pen, c_odd, c_two} = 4'b0100;
        send(8'hA5, 1'b1, 1'b1, 1'b1);
        check("R4 perr", err_parity, 1);
        check("R4 full", rx_full, 0);
        check("R9 irq_err", {irq_rx, irq_err}, 2'b01);
        send(8'h5A, 1'b0, 1'b1, 1'b1);
        check("R7 locked", {rx_full, rx_data}, {1'b0, 8'h00});
        pulse_clr();
        check("R10 clr", {err_overrun, err_parity, err_frame}, 0);
        send(8'h5A, 1'b0, 1'b1, 1'b1);
        check("R7 resume", {rx_full, rx_data}, {1'b1, 8'h5A});
        pulse_ack();

        // R5 framing error on first stop bit
        {c_short, c_pen, c_odd, c_two} = 4'b0000;
        send(8'h81, 1'b0, 1'b0, 1'b1);
        check("R5 ferr", err_frame, 1);
        check("R5 full", rx_full, 0);
        pulse_clr();
        // R5 second stop bit not examined
        c_two = 1'b1;
        send(8'h7E, 1'b0, 1'b1, 1'b0);
        check("R5 stop2", {err_frame, rx_full, rx_data}, {1'b0, 1'b1, 8'h7E});
        pulse_ack();
        c_two = 1'b0;

        // R6 overrun
        send(8'h11, 1'b0, 1'b1, 1'b1);
        send(8'h22, 1'b0, 1'b1, 1'b1);
        check("R6 ovr", err_overrun, 1);
        check("R6 keep", {rx_full, rx_data}, {1'b1, 8'h11});
        pulse_clr();
        pulse_ack();

        // R8 glitch rejection
        rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (300) @(negedge clk);
        check("R8 glitch", {rx_full, err_overrun, err_parity, err_frame}, 0);
        send(8'hC3, 1'b0, 1'b1, 1'b1);
        check("R8 after glitch", {rx_full, rx_data}, {1'b1, 8'hC3});
        pulse_ack();

        // R9 interrupt gated off
        irq_en = 1'b0;
        send(8'h99, 1'b0, 1'b1, 1'b1);
        check("R9 gated", {rx_full, irq_rx, irq_err}, 3'b100);
        pulse_ack();

        finish_run();
    end
endmodule